// File: doc/BRIEF.md
# Byte DMA Channel with Grouped Source Reload

This block is one burst-mode DMA channel. It copies single bytes from a peripheral result location to on-chip memory. Software sets a source address, a destination address and a transfer count through a small write-only configuration port, then enables the channel. When the peripheral raises its request, the channel asks for the bus and waits for a grant. It then runs read/write pairs back to back, without giving the bus up in between.

The reload option suits a peripheral that exposes a short window of result registers. With reload on, the source address steps through a group of four locations and then returns to its programmed start. At the end of each group the channel also drops its bus request and waits for a new request before it starts the next group. The destination address keeps advancing in every case. When the last transfer is done, the channel turns itself off and can raise an interrupt. The interrupt stays high until software clears it.

Top module: `dma_reload_chan`

## Requirements
- R1: The configuration port is written on a clock edge with `cfg_we` high. The offset in `cfg_addr` selects the register: 0 is the source start (this also loads the current source address and restarts the group), 1 is the destination, 2 is the transfer count and 3 is control. The control bits are: bit 0 enable, bit 1 reload, bit 2 interrupt enable, and bit 3 which clears the interrupt when written as 1.
- R2: After reset, `bus_req_o`, `mem_rd_o`, `mem_wr_o` and `irq_o` are low and the channel is disabled.
- R3: While the channel is idle, enabled and has a nonzero count, a high `req_i` at a clock edge makes `bus_req_o` high from the next cycle on.
- R4: Each transfer has two cycles. The first is a read cycle (`mem_rd_o` high, `mem_addr_o` = source), which starts on the first edge where the grant is sampled high. The second is a write cycle directly after it (`mem_wr_o` high, `mem_addr_o` = destination, `mem_wdata_o` = the byte read).
- R5: The destination address increases by one after every transfer, whether reload is on or off.
- R6: With reload off, the source address increases by one after every transfer. The whole count runs as one burst, with `bus_req_o` held high from the first transfer to the last.
- R7: With reload on, the source address goes back to its start value after the fourth transfer of each group, so transfer n reads the start address plus (n mod 4).
- R8: With reload on, `bus_req_o` falls in the cycle after the write of the fourth transfer of a group. The next group starts only through a new request and a new request/grant handshake.
- R9: The count drops by one per transfer. When it reaches zero, the channel disables itself and releases the bus, and later requests start no transfer.
- R10: When the count reaches zero and interrupt enable is set, `irq_o` rises. It stays high until a control write with bit 3 set. With interrupt enable clear, `irq_o` stays low.
- R11: Enabling the channel with a count of zero finishes it at once: no bus request is made, and `irq_o` rises if interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register offset |
| cfg_wdata | input | AW (32) | Configuration write data |
| req_i | input | 1 | Peripheral transfer request |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership grant |
| mem_rd_o | output | 1 | Read cycle strobe |
| mem_wr_o | output | 1 | Write cycle strobe |
| mem_addr_o | output | AW (32) | Master address |
| mem_wdata_o | output | DW (8) | Write data |
| mem_rdata_i | input | DW (8) | Read data, sampled at the end of the read cycle |
| irq_o | output | 1 | End-of-transfer interrupt |

## Verification
The assertions assume three things about the inputs. First, the grant is given only while the bus request is high, and it stays high until the request drops. Second, the read data is valid within the read cycle. Third, software does not write the configuration port while a transfer is running. The stimulus keeps to all three. Its grant model raises the grant after a random delay and removes it once the request falls. Its memory model returns a byte computed from the address in the same cycle. Configuration writes are made only when the channel is idle and every transfer of the job has been seen.

// File: rtl/dma_reload_pkg.sv
package dma_reload_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_RD, ST_WR} ch_state_e;

    localparam logic [1:0] OFS_SRC = 2'd0;
    localparam logic [1:0] OFS_DST = 2'd1;
    localparam logic [1:0] OFS_CNT = 2'd2;
    localparam logic [1:0] OFS_CTL = 2'd3;

    localparam int CTL_EN  = 0;
    localparam int CTL_RLD = 1;
    localparam int CTL_IE  = 2;
    localparam int CTL_CLR = 3;
endpackage

// File: rtl/dma_reload_regs.sv
module dma_reload_regs
    import dma_reload_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int GRP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          step_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic          en_o,
    output logic          rld_o,
    output logic          zero_o,
    output logic          last_o,
    output logic          grp_last_o,
    output logic          irq_o
);
    localparam int GW = (GRP > 1) ? $clog2(GRP) : 1;
    localparam logic [GW-1:0] GLAST = GW'(GRP - 1);
    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] start;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic [GW-1:0] grp;
        logic          en;
        logic          rld;
        logic          ie;
        logic          irq;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (cfg_we) begin
            case (cfg_addr)
                OFS_SRC: begin
                    d.src   = cfg_wdata;
                    d.start = cfg_wdata;
                    d.grp   = '0;
                end
                OFS_DST: d.dst = cfg_wdata;
                OFS_CNT: d.cnt = cfg_wdata[CW-1:0];
                default: begin
                    d.en  = cfg_wdata[CTL_EN];
                    d.rld = cfg_wdata[CTL_RLD];
                    d.ie  = cfg_wdata[CTL_IE];
                    if (cfg_wdata[CTL_CLR]) d.irq = 1'b0;
                    if (cfg_wdata[CTL_EN])  d.grp = '0;
                end
            endcase
        end
        if (q.en && (q.cnt == '0)) begin
            d.en = 1'b0;
            if (q.ie) d.irq = 1'b1;
        end
        if (step_i) begin
            d.dst = q.dst + A_ONE;
            d.cnt = q.cnt - C_ONE;
            if (q.grp == GLAST) begin
                d.grp = '0;
                d.src = q.rld ? q.start : q.src + A_ONE;
            end else begin
                d.grp = q.grp + GW'(1);
                d.src = q.src + A_ONE;
            end
            if (q.cnt == C_ONE) begin
                d.en = 1'b0;
                if (q.ie) d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign src_o      = q.src;
    assign dst_o      = q.dst;
    assign en_o       = q.en;
    assign rld_o      = q.rld;
    assign zero_o     = (q.cnt == '0);
    assign last_o     = (q.cnt == C_ONE);
    assign grp_last_o = (q.grp == GLAST);
    assign irq_o      = q.irq;

    // R5: destination advances by one per transfer
    a_r5_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cfg_we) |=> (dst_o == $past(dst_o) + A_ONE));
    // R7: group end with reload returns to the start address
    a_r7_src_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cfg_we && rld_o && grp_last_o) |=> (src_o == q.start));
    // R6: without reload the source keeps advancing
    a_r6_src_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cfg_we && !rld_o) |=> (src_o == $past(src_o) + A_ONE));
    // R9: final transfer disables the channel
    a_r9_self_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cfg_we && last_o) |=> (!en_o && zero_o));
    // R11: enabling with zero count finishes at once
    a_r11_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && zero_o && !cfg_we) |=> !en_o);
    // R10: interrupt holds until a clearing control write
    a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(cfg_we && cfg_addr == OFS_CTL && cfg_wdata[CTL_CLR])) |=> irq_o);
endmodule

// File: rtl/dma_reload_ctrl.sv
module dma_reload_ctrl
    import dma_reload_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          bus_gnt_i,
    input  logic          en_i,
    input  logic          rld_i,
    input  logic          zero_i,
    input  logic          last_i,
    input  logic          grp_last_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          step_o,
    output logic          bus_req_o,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o
);
    typedef struct packed {
        ch_state_e     st;
        logic [DW-1:0] data;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d      = q;
        step_o = 1'b0;
        case (q.st)
            ST_IDLE: if (en_i && !zero_i && req_i) d.st = ST_ARB;
            ST_ARB:  if (bus_gnt_i) d.st = ST_RD;
            ST_RD: begin
                d.data = mem_rdata_i;
                d.st   = ST_WR;
            end
            default: begin
                step_o = 1'b1;
                d.st   = (last_i || (rld_i && grp_last_i)) ? ST_IDLE : ST_RD;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, data: '0};
        else        q <= d;
    end

    assign bus_req_o   = (q.st != ST_IDLE);
    assign mem_rd_o    = (q.st == ST_RD);
    assign mem_wr_o    = (q.st == ST_WR);
    assign mem_addr_o  = (q.st == ST_WR) ? dst_i : src_i;
    assign mem_wdata_o = q.data;

    // R4: a write cycle always follows a read cycle, carrying the byte read
    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> (mem_wr_o && mem_wdata_o == $past(mem_rdata_i)));
    // R4: strobes never overlap
    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));
    // R8: bus released after the last transfer of a reload group
    a_r8_group_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && rld_i && grp_last_i) |=> !bus_req_o);
    // R3: bus traffic only while the request is held
    a_r3_req_during_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> bus_req_o);
    // R6: inside a burst without reload the bus stays requested
    a_r6_burst_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !rld_i && !last_i) |=> (bus_req_o && mem_rd_o));
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
    import dma_reload_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 8,
    parameter int CW  = 16,
    parameter int GRP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_i,
    output logic          bus_req_o,
    input  logic          bus_gnt_i,
    output logic          mem_rd_o,
    output logic          mem_wr_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          irq_o
);
    logic [AW-1:0] src, dst;
    logic en, rld, zero, last, grp_last, step;

    dma_reload_regs #(.AW(AW), .CW(CW), .GRP(GRP)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .step_i(step), .src_o(src), .dst_o(dst),
        .en_o(en), .rld_o(rld), .zero_o(zero), .last_o(last),
        .grp_last_o(grp_last), .irq_o(irq_o)
    );

    dma_reload_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_gnt_i(bus_gnt_i),
        .en_i(en), .rld_i(rld), .zero_i(zero), .last_i(last),
        .grp_last_i(grp_last), .src_i(src), .dst_i(dst),
        .mem_rdata_i(mem_rdata_i), .step_o(step), .bus_req_o(bus_req_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o)
    );
endmodule

// File: tb/dma_reload_chan_test.sv
module dma_reload_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_i = 1'b0;
    logic        bus_gnt_i = 1'b0;
    logic        bus_req_o, mem_rd_o, mem_wr_o, irq_o;
    logic [31:0] mem_addr_o;
    logic [7:0]  mem_wdata_o, mem_rdata_i;

    int total = 0, fails = 0, cycles = 0;
    int xfers = 0, rises = 0, reads = 0;
    bit prev_rd = 0, prev_breq = 0;
    logic [31:0] e_src0, e_dst0;
    bit e_rld;

    always #4 clk = ~clk;

    dma_reload_chan uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_i(req_i), .bus_req_o(bus_req_o),
        .bus_gnt_i(bus_gnt_i), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .irq_o(irq_o)
    );

    function automatic logic [7:0] data_of(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] exp_src(input int n);
        return e_rld ? e_src0 + 32'(n % 4) : e_src0 + 32'(n);
    endfunction

    assign mem_rdata_i = data_of(mem_addr_o);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            fails++; total++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // grant model: random delay, removed once request drops
    always @(negedge clk) begin
        if (!bus_req_o) bus_gnt_i <= 1'b0;
        else if (!bus_gnt_i && ($urandom % 2 == 0)) bus_gnt_i <= 1'b1;
    end

    // transfer monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req_o && !prev_breq) rises++;
            if (mem_rd_o) begin
                chk(mem_addr_o == exp_src(xfers), e_rld ? "R7" : "R6",
                    64'(mem_addr_o), 64'(exp_src(xfers)));
                chk(bus_gnt_i, "R4 grant", 64'(bus_gnt_i), 64'd1);
                reads++;
            end
            if (mem_wr_o) begin
                chk(prev_rd, "R4 order", 64'(prev_rd), 64'd1);
                chk(mem_addr_o == e_dst0 + 32'(xfers), "R5",
                    64'(mem_addr_o), 64'(e_dst0 + 32'(xfers)));
                chk(mem_wdata_o == data_of(exp_src(xfers)), "R4 data",
                    64'(mem_wdata_o), 64'(data_of(exp_src(xfers))));
                xfers++;
            end
            prev_rd   = mem_rd_o;
            prev_breq = bus_req_o;
        end
    end

    task automatic cfg(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_job(input logic [31:0] s, input logic [31:0] dd,
                           input int cnt, input bit rld, input bit ie);
        int guard = 0;
        int exp_rises;
        e_src0 = s; e_dst0 = dd; e_rld = rld;
        xfers = 0; rises = 0; reads = 0;
        cfg(2'd0, s);
        cfg(2'd1, dd);
        cfg(2'd2, 32'(cnt));
        cfg(2'd3, {28'd0, 1'b1, ie, rld, 1'b1});
        while (!(xfers == cnt && !bus_req_o) && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (req_i) begin
                chk(bus_req_o, "R3", 64'(bus_req_o), 64'd1);
                req_i = 1'b0;
            end else if (!bus_req_o && xfers < cnt && ($urandom % 3 == 0)) begin
                req_i = 1'b1;
            end
        end
        req_i = 1'b0;
        exp_rises = (cnt == 0) ? 0 : (rld ? (cnt + 3) / 4 : 1);
        chk(xfers == cnt, "R9 count", 64'(xfers), 64'(cnt));
        chk(rises == exp_rises, rld ? "R8 release" : "R6 burst",
            64'(rises), 64'(exp_rises));
        repeat (2) @(negedge clk);
        chk(irq_o == ie, "R10 irq", 64'(irq_o), 64'(ie));
        // later requests must start nothing
        req_i = 1'b1;
        repeat (4) @(negedge clk);
        req_i = 1'b0;
        @(negedge clk);
        chk(rises == exp_rises && xfers == cnt, "R9 disabled",
            64'(rises), 64'(exp_rises));
        cfg(2'd3, 32'h8);
        @(negedge clk);
        chk(!irq_o, "R10 clear", 64'(irq_o), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!bus_req_o && !mem_rd_o && !mem_wr_o && !irq_o, "R2 reset",
            {60'd0, bus_req_o, mem_rd_o, mem_wr_o, irq_o}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        req_i = 1'b1;
        repeat (3) @(negedge clk);
        req_i = 1'b0;
        chk(!bus_req_o, "R2 disabled", 64'(bus_req_o), 64'd0);

        // R1 register map used throughout: 0 src, 1 dst, 2 count, 3 control
        run_job(32'hFFFF_8428, 32'hFFFF_F000, 9, 1'b0, 1'b1);  // R6
        run_job(32'hFFFF_8428, 32'hFFFF_F100, 8, 1'b1, 1'b1);  // R7 R8
        run_job(32'h0000_1000, 32'h0000_2000, 6, 1'b1, 1'b0);  // partial group
        run_job(32'h0000_30FE, 32'h0000_4000, 1, 1'b1, 1'b1);
        run_job(32'h0000_50FF, 32'h0000_6000, 5, 1'b0, 1'b0);

        // R11: zero count
        xfers = 0; rises = 0;
        cfg(2'd2, 32'd0);
        cfg(2'd3, 32'h5);
        req_i = 1'b1;
        repeat (5) @(negedge clk);
        req_i = 1'b0;
        chk(rises == 0 && xfers == 0, "R11 no bus", 64'(rises), 64'd0);
        chk(irq_o, "R11 irq", 64'(irq_o), 64'd1);
        cfg(2'd3, 32'h8);
        @(negedge clk);
        chk(!irq_o, "R10 clear zero", 64'(irq_o), 64'd0);

        for (int j = 0; j < 12; j++) begin
            run_job($urandom, $urandom, 1 + int'($urandom % 40),
                    1'($urandom % 2), 1'($urandom % 2));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule